// File: doc/BRIEF.md
# Two-Level I/O Page Table Walker

This block translates a 32-bit I/O virtual address into a physical address for one translation request at a time. It reads two 32-bit words in order: one from a 1024-entry page directory, then one from a 1024-entry page table. Each level fills exactly one 4 KiB page. Each address space ID (ASID) has its own directory base. Software loads a base by first writing the ASID into a select register and then writing a base word. The base word holds the directory frame number in its low bits and read, write and non-secure attributes in its top bits.

Word reads go out on a valid/ready request channel. A backing page-table cache or a memory answers on a valid/ready response channel. Only one read is in flight at any time. The walker raises `mem_rsp_ready` only while it waits for a word, and a response must not arrive at any other time.

The translation request and result are valid/ready streams. A request is taken only while the walker is idle (`req_ready` high). A result is held stable until `res_ready` is seen. On a successful walk, a single-cycle fill pulse carries the new translation to a TLB. The fill has no back-pressure.

Top module: `iopt_walker`

## Requirements
- R1: The directory read address is {directory frame, va[31:22], 2'b00}. The table read address is {directory-entry frame, va[21:12], 2'b00}. Frame numbers are the low ADDR_BITS-12 bits of the word that holds them.
- R2: A walk issues at most two reads, directory first and table second. Each read request holds its address stable until `mem_req_ready` is seen.
- R3: `asid_sel_we` loads `asid_sel_data` into the select register. `base_we` stores `base_data` into the base slot of the selected ASID: the frame is in the low bits, read is bit 31, write is bit 30 and non-secure is bit 29. A walk uses the base of its own `req_asid`, taken at the cycle the request is accepted.
- R4: If bit 28 of the directory entry (next-level) is clear, the result is a translation fault (`res_fault`=1) with `res_pa`=0. The walk makes no table read and produces no fill.
- R5: An all-zero table entry gives a translation fault (`res_fault`=1) with `res_pa`=0 and no fill.
- R6: The effective permission is the bitwise AND of the read, write and non-secure bits of the base, the directory entry and the table entry. A read (`req_write`=0) needs effective read. A write needs effective write. If the needed bit is missing, the result is a permission fault (`res_fault`=2) with `res_pa`=0, and `res_va` and `res_asid` carry the request.
- R7: On success, `res_fault`=0 and `res_pa` = (table-entry frame << 12) | va[11:0]. Table-entry bits between the frame and bit 29 are ignored. `res_perm` = {read, write, non-secure} effective.
- R8: A successful walk pulses `fill_valid` for exactly one cycle, in the first cycle of its result. The pulse carries the ASID, va[31:12], the frame and the effective permission. A fault gives no pulse.
- R9: `req_ready` is high only when no walk is active and no result is pending. `res_valid`, `res_pa`, `res_fault` and `res_perm` hold until `res_ready` is seen.
- R10: After reset, `req_ready`=1 and `res_valid`, `mem_req_valid` and `fill_valid` are 0. All base slots are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| asid_sel_we | input | 1 | Load the ASID select register |
| asid_sel_data | input | ASID_W | ASID to select for base writes |
| base_we | input | 1 | Write the base word of the selected ASID |
| base_data | input | 32 | Base word: attributes in 31:29, frame in the low bits |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and accepting |
| req_va | input | 32 | Virtual address |
| req_asid | input | ASID_W | Address space of the request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| mem_req_valid | output | 1 | Word read request valid |
| mem_req_ready | input | 1 | Word read request accepted |
| mem_req_addr | output | ADDR_BITS | Byte address of the word |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Walker waiting for read data |
| mem_rsp_data | input | 32 | Entry word |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result consumed |
| res_pa | output | ADDR_BITS | Physical address (0 on fault) |
| res_fault | output | 2 | 0 none, 1 translation, 2 permission |
| res_perm | output | 3 | Effective {read, write, non-secure} |
| res_va | output | 32 | Virtual address of the result |
| res_asid | output | ASID_W | ASID of the result |
| fill_valid | output | 1 | One-cycle TLB fill strobe |
| fill_asid | output | ASID_W | Fill ASID |
| fill_vpn | output | 20 | Fill virtual page number |
| fill_frame | output | ADDR_BITS-12 | Fill physical frame |
| fill_perm | output | 3 | Fill permission |

## Verification
The embedded assertions check several rules on every cycle:
- read requests and results hold steady under back-pressure;
- the fill strobe lasts one cycle and appears only alongside a fault-free result;
- a faulting result always carries a zero address;
- request acceptance never overlaps an active walk.

Only the directed scenarios can show the rest:
- the values themselves: the read addresses built from each index field, the AND of the three levels' attributes, and the masking of the frame;
- the order and number of reads, including the single read when the next-level flag is missing;
- that each ASID selects its own directory.

// File: rtl/iopt_pkg.sv
package iopt_pkg;
  localparam int unsigned PAGE_SHIFT = 12;
  localparam int unsigned IDX_W      = 10;
  localparam int unsigned ATTR_RD    = 31;
  localparam int unsigned ATTR_WR    = 30;
  localparam int unsigned ATTR_NS    = 29;
  localparam int unsigned ATTR_NEXT  = 28;
  // positions inside a 3-bit permission vector {rd, wr, ns}
  localparam int unsigned P_RD = 2;
  localparam int unsigned P_WR = 1;
  localparam int unsigned P_NS = 0;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_XLATE = 2'd1,
    FLT_PERM  = 2'd2
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR_REQ,
    ST_DIR_WAIT,
    ST_TBL_REQ,
    ST_TBL_WAIT,
    ST_DONE
  } walk_st_e;
endpackage

// File: rtl/iopt_base_table.sv
module iopt_base_table
  import iopt_pkg::*;
#(
  parameter int ASID_W  = 7,
  parameter int FRAME_W = 22
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_we,
  input  logic [ASID_W-1:0]  sel_data,
  input  logic               base_we,
  input  logic [31:0]        base_data,
  input  logic [ASID_W-1:0]  rd_asid,
  output logic [FRAME_W-1:0] rd_frame,
  output logic [2:0]         rd_perm
);
  localparam int NUM_SLOTS = 1 << ASID_W;
  localparam int SLOT_W    = FRAME_W + 3;

  logic [ASID_W-1:0] sel_q;
  logic [SLOT_W-1:0] slot_q [NUM_SLOTS];
  logic [SLOT_W-1:0] wr_word;
  logic              unused_base;

  assign wr_word     = {base_data[ATTR_RD], base_data[ATTR_WR], base_data[ATTR_NS],
                        base_data[FRAME_W-1:0]};
  assign unused_base = ^base_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else if (sel_we) sel_q <= sel_data;
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[g] <= '0;
      else if (base_we && (sel_q == ASID_W'(g))) slot_q[g] <= wr_word;
    end
  end

  assign rd_frame = slot_q[rd_asid][FRAME_W-1:0];
  assign rd_perm  = slot_q[rd_asid][SLOT_W-1:FRAME_W];
endmodule

// File: rtl/iopt_entry_decode.sv
module iopt_entry_decode
  import iopt_pkg::*;
#(
  parameter int FRAME_W = 22
) (
  input  logic [31:0]        word,
  output logic [FRAME_W-1:0] frame,
  output logic [2:0]         perm,
  output logic               has_next,
  output logic               mapped
);
  assign frame    = word[FRAME_W-1:0];
  assign perm     = {word[ATTR_RD], word[ATTR_WR], word[ATTR_NS]};
  assign has_next = word[ATTR_NEXT];
  assign mapped   = |word;
endmodule

// File: rtl/iopt_walk_fsm.sv
module iopt_walk_fsm
  import iopt_pkg::*;
#(
  parameter int ASID_W    = 7,
  parameter int ADDR_BITS = 34,
  parameter int FRAME_W   = ADDR_BITS - 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [31:0]          req_va,
  input  logic [ASID_W-1:0]    req_asid,
  input  logic                 req_write,
  input  logic [FRAME_W-1:0]   lk_frame,
  input  logic [2:0]           lk_perm,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic [ADDR_BITS-1:0] mem_req_addr,
  input  logic                 mem_rsp_valid,
  output logic                 mem_rsp_ready,
  input  logic [FRAME_W-1:0]   ent_frame,
  input  logic [2:0]           ent_perm,
  input  logic                 ent_next,
  input  logic                 ent_mapped,
  output logic                 res_valid,
  input  logic                 res_ready,
  output logic [ADDR_BITS-1:0] res_pa,
  output logic [1:0]           res_fault,
  output logic [2:0]           res_perm,
  output logic [31:0]          res_va,
  output logic [ASID_W-1:0]    res_asid,
  output logic                 res_write,
  output logic                 fill_valid
);
  walk_st_e             st_q;
  logic [31:0]          va_q;
  logic [ASID_W-1:0]    asid_q;
  logic                 wr_q;
  logic [FRAME_W-1:0]   dir_frame_q;
  logic [FRAME_W-1:0]   tbl_frame_q;
  logic [2:0]           perm_acc_q;
  logic [ADDR_BITS-1:0] pa_q;
  fault_e               fault_q;
  logic [2:0]           perm_q;
  logic                 fill_q;
  logic [2:0]           eff_perm;
  logic                 allowed;

  assign eff_perm = perm_acc_q & ent_perm;
  assign allowed  = wr_q ? eff_perm[P_WR] : eff_perm[P_RD];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      va_q        <= '0;
      asid_q      <= '0;
      wr_q        <= 1'b0;
      dir_frame_q <= '0;
      tbl_frame_q <= '0;
      perm_acc_q  <= '0;
      pa_q        <= '0;
      fault_q     <= FLT_NONE;
      perm_q      <= '0;
      fill_q      <= 1'b0;
    end else begin
      fill_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            va_q        <= req_va;
            asid_q      <= req_asid;
            wr_q        <= req_write;
            dir_frame_q <= lk_frame;
            perm_acc_q  <= lk_perm;
            st_q        <= ST_DIR_REQ;
          end
        end
        ST_DIR_REQ: if (mem_req_ready) st_q <= ST_DIR_WAIT;
        ST_DIR_WAIT: begin
          if (mem_rsp_valid) begin
            if (!ent_next) begin
              fault_q <= FLT_XLATE;
              pa_q    <= '0;
              perm_q  <= '0;
              st_q    <= ST_DONE;
            end else begin
              tbl_frame_q <= ent_frame;
              perm_acc_q  <= perm_acc_q & ent_perm;
              st_q        <= ST_TBL_REQ;
            end
          end
        end
        ST_TBL_REQ: if (mem_req_ready) st_q <= ST_TBL_WAIT;
        ST_TBL_WAIT: begin
          if (mem_rsp_valid) begin
            st_q <= ST_DONE;
            if (!ent_mapped) begin
              fault_q <= FLT_XLATE;
              pa_q    <= '0;
              perm_q  <= '0;
            end else if (!allowed) begin
              fault_q <= FLT_PERM;
              pa_q    <= '0;
              perm_q  <= eff_perm;
            end else begin
              fault_q <= FLT_NONE;
              pa_q    <= {ent_frame, va_q[PAGE_SHIFT-1:0]};
              perm_q  <= eff_perm;
              fill_q  <= 1'b1;
            end
          end
        end
        ST_DONE: if (res_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (st_q == ST_IDLE);
  assign mem_req_valid = (st_q == ST_DIR_REQ) || (st_q == ST_TBL_REQ);
  assign mem_rsp_ready = (st_q == ST_DIR_WAIT) || (st_q == ST_TBL_WAIT);
  assign mem_req_addr  = (st_q == ST_TBL_REQ)
                       ? {tbl_frame_q, va_q[PAGE_SHIFT+IDX_W-1:PAGE_SHIFT], 2'b00}
                       : {dir_frame_q, va_q[31:PAGE_SHIFT+IDX_W], 2'b00};
  assign res_valid     = (st_q == ST_DONE);
  assign res_pa        = pa_q;
  assign res_fault     = fault_q;
  assign res_perm      = perm_q;
  assign res_va        = va_q;
  assign res_asid      = asid_q;
  assign res_write     = wr_q;
  assign fill_valid    = fill_q;

  // R2: a read request keeps its address until taken
  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  // R9: result held under back-pressure
  a_r9_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_pa) && $stable(res_fault)
                                && $stable(res_perm));
  // R9: acceptance never overlaps an active walk
  a_r9_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !res_valid && !mem_req_valid && !mem_rsp_ready);
  // R8: fill only with a clean result, one cycle long
  a_r8_fill_clean: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> res_valid && (res_fault == 2'd0));
  a_r8_fill_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> !fill_valid);
  // R4/R5/R6: faulting results carry no address
  a_r4_fault_zero_pa: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && (res_fault != 2'd0) |-> (res_pa == '0));
endmodule

// File: rtl/iopt_walker.sv
module iopt_walker
  import iopt_pkg::*;
#(
  parameter int ADDR_BITS = 34,
  parameter int ASID_W    = 7,
  parameter int FRAME_W   = ADDR_BITS - 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 asid_sel_we,
  input  logic [ASID_W-1:0]    asid_sel_data,
  input  logic                 base_we,
  input  logic [31:0]          base_data,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [31:0]          req_va,
  input  logic [ASID_W-1:0]    req_asid,
  input  logic                 req_write,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic [ADDR_BITS-1:0] mem_req_addr,
  input  logic                 mem_rsp_valid,
  output logic                 mem_rsp_ready,
  input  logic [31:0]          mem_rsp_data,
  output logic                 res_valid,
  input  logic                 res_ready,
  output logic [ADDR_BITS-1:0] res_pa,
  output logic [1:0]           res_fault,
  output logic [2:0]           res_perm,
  output logic [31:0]          res_va,
  output logic [ASID_W-1:0]    res_asid,
  output logic                 fill_valid,
  output logic [ASID_W-1:0]    fill_asid,
  output logic [19:0]          fill_vpn,
  output logic [FRAME_W-1:0]   fill_frame,
  output logic [2:0]           fill_perm
);
  logic [FRAME_W-1:0] lk_frame;
  logic [2:0]         lk_perm;
  logic [FRAME_W-1:0] ent_frame;
  logic [2:0]         ent_perm;
  logic               ent_next;
  logic               ent_mapped;
  logic               res_write_unused;

  iopt_base_table #(.ASID_W(ASID_W), .FRAME_W(FRAME_W)) u_base (
    .clk(clk), .rst_n(rst_n),
    .sel_we(asid_sel_we), .sel_data(asid_sel_data),
    .base_we(base_we), .base_data(base_data),
    .rd_asid(req_asid), .rd_frame(lk_frame), .rd_perm(lk_perm)
  );

  iopt_entry_decode #(.FRAME_W(FRAME_W)) u_dec (
    .word(mem_rsp_data), .frame(ent_frame), .perm(ent_perm),
    .has_next(ent_next), .mapped(ent_mapped)
  );

  iopt_walk_fsm #(.ASID_W(ASID_W), .ADDR_BITS(ADDR_BITS), .FRAME_W(FRAME_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .req_asid(req_asid), .req_write(req_write),
    .lk_frame(lk_frame), .lk_perm(lk_perm),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready),
    .ent_frame(ent_frame), .ent_perm(ent_perm), .ent_next(ent_next),
    .ent_mapped(ent_mapped),
    .res_valid(res_valid), .res_ready(res_ready), .res_pa(res_pa),
    .res_fault(res_fault), .res_perm(res_perm), .res_va(res_va),
    .res_asid(res_asid), .res_write(res_write_unused), .fill_valid(fill_valid)
  );

  assign fill_asid  = res_asid;
  assign fill_vpn   = res_va[31:PAGE_SHIFT];
  assign fill_frame = res_pa[ADDR_BITS-1:PAGE_SHIFT];
  assign fill_perm  = res_perm;

  // R6: a permission fault never comes with an access the result permits
  a_r6_perm_consistent: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && (res_fault == 2'd2) |->
      (res_write_unused ? !res_perm[P_WR] : !res_perm[P_RD]));
endmodule

// File: tb/iopt_walker_tb.sv
`timescale 1ns/1ps
module iopt_walker_tb_top;
  localparam int PA_W  = 34;
  localparam int AW    = 7;
  localparam int FW    = PA_W - 12;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            asid_sel_we, base_we;
  logic [AW-1:0]   asid_sel_data;
  logic [31:0]     base_data;
  logic            req_valid, req_ready, req_write;
  logic [31:0]     req_va;
  logic [AW-1:0]   req_asid;
  logic            mem_req_valid, mem_req_ready;
  logic [PA_W-1:0] mem_req_addr;
  logic            mem_rsp_valid, mem_rsp_ready;
  logic [31:0]     mem_rsp_data;
  logic            res_valid, res_ready;
  logic [PA_W-1:0] res_pa;
  logic [1:0]      res_fault;
  logic [2:0]      res_perm;
  logic [31:0]     res_va;
  logic [AW-1:0]   res_asid;
  logic            fill_valid;
  logic [AW-1:0]   fill_asid;
  logic [19:0]     fill_vpn;
  logic [FW-1:0]   fill_frame;
  logic [2:0]      fill_perm;

  always #4 clk = ~clk;

  iopt_walker #(.ADDR_BITS(PA_W), .ASID_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .asid_sel_we(asid_sel_we), .asid_sel_data(asid_sel_data),
    .base_we(base_we), .base_data(base_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .req_asid(req_asid), .req_write(req_write),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_pa(res_pa),
    .res_fault(res_fault), .res_perm(res_perm), .res_va(res_va),
    .res_asid(res_asid), .fill_valid(fill_valid), .fill_asid(fill_asid),
    .fill_vpn(fill_vpn), .fill_frame(fill_frame), .fill_perm(fill_perm)
  );

  int n_checks = 0;
  int n_errs   = 0;
  logic [31:0]     mem_q [logic [PA_W-1:0]];
  int              mem_lat = 2;
  int              stall_left = 0;
  int              rd_cnt = 0;
  logic [PA_W-1:0] rd_log [4];
  int              fill_cnt = 0;
  logic [AW-1:0]   f_asid;
  logic [19:0]     f_vpn;
  logic [FW-1:0]   f_frame;
  logic [2:0]      f_perm;
  logic [PA_W-1:0] got_pa;
  logic [1:0]      got_fault;
  logic [2:0]      got_perm;
  logic [31:0]     got_va;
  logic [AW-1:0]   got_asid;
  logic            hold_ok;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [PA_W-1:0] dir_addr(input logic [FW-1:0] fr, input logic [31:0] va);
    return {fr, va[31:22], 2'b00};
  endfunction
  function automatic logic [PA_W-1:0] tbl_addr(input logic [FW-1:0] fr, input logic [31:0] va);
    return {fr, va[21:12], 2'b00};
  endfunction

  // memory model: one outstanding read, fixed latency, optional request stall
  initial begin
    logic [PA_W-1:0] pend;
    int cnt;
    cnt = 0; pend = '0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      if (mem_rsp_valid) mem_rsp_valid = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem_q.exists(pend) ? mem_q[pend] : 32'h0;
        end
      end
      if (stall_left > 0) begin mem_req_ready = 1'b0; stall_left--; end
      else mem_req_ready = 1'b1;
      if (mem_req_valid && mem_req_ready && rst_n) begin
        pend = mem_req_addr;
        cnt  = mem_lat;
        if (rd_cnt < 4) rd_log[rd_cnt] = mem_req_addr;
        rd_cnt++;
      end
    end
  end

  // fill monitor
  initial begin
    forever begin
      @(negedge clk);
      if (fill_valid) begin
        fill_cnt++;
        f_asid = fill_asid; f_vpn = fill_vpn; f_frame = fill_frame; f_perm = fill_perm;
      end
    end
  end

  task automatic set_base(input logic [AW-1:0] asid, input logic [31:0] data);
    asid_sel_we = 1'b1; asid_sel_data = asid;
    @(negedge clk);
    asid_sel_we = 1'b0; base_we = 1'b1; base_data = data;
    @(negedge clk);
    base_we = 1'b0;
  endtask

  task automatic set_map(input logic [FW-1:0] dfr, input logic [31:0] va,
                         input logic [31:0] pde, input logic [31:0] pte);
    mem_q[dir_addr(dfr, va)] = pde;
    if (pde[28]) mem_q[tbl_addr(pde[FW-1:0], va)] = pte;
  endtask

  task automatic walk(input logic [31:0] va, input logic [AW-1:0] asid,
                      input logic wr, input int hold);
    rd_cnt = 0; fill_cnt = 0; hold_ok = 1'b1;
    req_va = va; req_asid = asid; req_write = wr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!res_valid) @(negedge clk);
    got_pa = res_pa; got_fault = res_fault; got_perm = res_perm;
    got_va = res_va; got_asid = res_asid;
    repeat (hold) begin
      @(negedge clk);
      if (!res_valid || req_ready || res_pa !== got_pa || res_fault !== got_fault)
        hold_ok = 1'b0;
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10 req_ready", req_ready, 1);
    chk("R10 res_valid", res_valid, 0);
    chk("R10 mem_req_valid", mem_req_valid, 0);
    chk("R10 fill_valid", fill_valid, 0);
  endtask

  task automatic t_read_ok;
    logic [31:0] va = 32'h1234_5678;
    set_map(22'h100, va, 32'hF000_0200, 32'hE000_3ABC);
    walk(va, 7'd3, 1'b0, 0);
    chk("R7 fault", got_fault, 0);
    chk("R7 pa", got_pa, {22'h3ABC, va[11:0]});
    chk("R7 perm", got_perm, 3'b111);
    chk("R2 read count", rd_cnt, 2);
    chk("R1 dir addr", rd_log[0], dir_addr(22'h100, va));
    chk("R1 tbl addr", rd_log[1], tbl_addr(22'h200, va));
    chk("R8 fill count", fill_cnt, 1);
    chk("R8 fill asid", f_asid, 7'd3);
    chk("R8 fill vpn", f_vpn, va[31:12]);
    chk("R8 fill frame", f_frame, 22'h3ABC);
    chk("R8 fill perm", f_perm, 3'b111);
  endtask

  task automatic t_write_hold;
    logic [31:0] va = 32'hABC0_1FFF;
    set_map(22'h100, va, 32'hF000_0210, 32'hC001_2345);
    stall_left = 3;
    walk(va, 7'd3, 1'b1, 4);
    chk("R9 result held, no accept", hold_ok, 1);
    chk("R2 stalled read count", rd_cnt, 2);
    chk("R7 write pa", got_pa, {22'h12345, 12'hFFF});
    chk("R6 ns anded", got_perm, 3'b110);
    chk("R8 write fill", fill_cnt, 1);
  endtask

  task automatic t_perm_faults;
    logic [31:0] va = 32'h0040_2004;
    set_map(22'h100, va, 32'hF000_0220, 32'hA000_0777);
    walk(va, 7'd3, 1'b1, 0);
    chk("R6 write denied fault", got_fault, 2);
    chk("R6 fault pa", got_pa, 0);
    chk("R6 fault perm", got_perm, 3'b101);
    chk("R6 fault va", got_va, va);
    chk("R6 fault asid", got_asid, 7'd3);
    chk("R8 no fill on fault", fill_cnt, 0);
    va = 32'h00C0_5010;
    set_map(22'h100, va, 32'hF000_0230, 32'h6000_0055);
    walk(va, 7'd3, 1'b0, 0);
    chk("R6 read denied fault", got_fault, 2);
    chk("R6 read denied perm", got_perm, 3'b011);
    va = 32'h0140_0000;
    set_map(22'h100, va, 32'hB000_0270, 32'hE000_0111);
    walk(va, 7'd3, 1'b1, 0);
    chk("R6 directory write bit clear", got_fault, 2);
    chk("R6 directory perm", got_perm, 3'b101);
  endtask

  task automatic t_xlate_faults;
    logic [31:0] va = 32'hFFC0_0ABC;
    set_map(22'h100, va, 32'hE000_0300, 32'h0);
    walk(va, 7'd3, 1'b0, 0);
    chk("R4 no-next fault", got_fault, 1);
    chk("R4 single read", rd_cnt, 1);
    chk("R4 pa zero", got_pa, 0);
    chk("R4 no fill", fill_cnt, 0);
    va = 32'h0080_0123;
    set_map(22'h100, va, 32'hF000_0240, 32'h0);
    walk(va, 7'd3, 1'b0, 0);
    chk("R5 unmapped fault", got_fault, 1);
    chk("R5 two reads", rd_cnt, 2);
    chk("R5 no fill", fill_cnt, 0);
  endtask

  task automatic t_mask;
    logic [31:0] va = 32'h0100_0FED;
    set_map(22'h100, va, 32'hF000_0250, 32'hBFFF_FFFF);
    walk(va, 7'd3, 1'b0, 0);
    chk("R7 masked pa", got_pa, {22'h3F_FFFF, 12'hFED});
    chk("R7 masked perm", got_perm, 3'b101);
  endtask

  task automatic t_asid;
    logic [31:0] va = 32'h1234_5678;
    set_map(22'h400, va, 32'hF000_0260, 32'hE000_0999);
    walk(va, 7'd5, 1'b0, 0);
    chk("R3 own directory", rd_log[0], dir_addr(22'h400, va));
    chk("R3 asid5 pa", got_pa, {22'h999, va[11:0]});
    chk("R3 base attrs", got_perm, 3'b101);
    walk(va, 7'd5, 1'b1, 0);
    chk("R6 base write bit clear", got_fault, 2);
    walk(va, 7'd3, 1'b0, 0);
    chk("R3 asid3 unaffected", got_pa, {22'h3ABC, va[11:0]});
  endtask

  initial begin
    rst_n = 1'b0; asid_sel_we = 0; asid_sel_data = '0; base_we = 0; base_data = '0;
    req_valid = 0; req_va = '0; req_asid = '0; req_write = 0; res_ready = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    set_base(7'd3, 32'hE000_0100);
    set_base(7'd5, 32'hA000_0400);
    t_read_ok();
    t_write_hold();
    t_perm_faults();
    t_xlate_faults();
    t_mask();
    t_asid();
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_errs++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule